// File: doc/BRIEF.md
# Daisy-Chain Serial Converter Write Sequencer

This block sits on the host side of a chain of serial digital-to-analog converters. All devices in the chain share one chip-select line, one serial clock and one load line. Each device's serial input is fed from the serial output of the device nearer the host. A single parallel request carries one 24-bit command word per device. The sequencer writes the whole chain in one transaction and then triggers a simultaneous update of all outputs.

Each 24-bit word follows the device command layout: bit 23 selects the channel, bit 21 requests quick load, and bits 15..0 carry the code. The sequencer does not interpret these fields; it only moves them. A transaction proceeds in a fixed order:

1. Chip-select falls while the clock is parked high.
2. The 24*N bits are clocked out. Data changes in each low clock phase and is committed by the rising clock edge.
3. Chip-select rises while the clock is still high, so no spurious edge reaches the devices.
4. The load line is pulsed low to move the shifted words into the input registers.
5. The latch line is pulsed high. Its rising edge updates every output together.

The speed of the serial clock is set by a divider parameter. A request is only taken while the sequencer is idle.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, and whenever the sequencer is idle, cs_n=1, sclk=1, load_n=1, ldac=0, sdata=0, busy=0 and done=0.
- R2: A start seen high at a clock edge while idle is accepted. In the following cycle busy=1 and cs_n=0, with sclk still high for one phase before the first bit.
- R3: Every serial phase (clock low, clock high, chip-select setup, chip-select release, load pulse, latch pulse, latch release) lasts exactly CLK_DIV system cycles.
- R4: Exactly 24*CHAIN_LEN bits are sent, MSB first, starting with frames[24*CHAIN_LEN-1]. Word k occupies frames[24k+23:24k] and is intended for device k, where device 0 is nearest the host. The farthest device's word is therefore sent first.
- R5: Each bit is one low phase followed by one high phase of sclk. sdata changes only at the start of a low phase and is stable across every rising edge. sclk is low only while cs_n=0.
- R6: cs_n rises only while sclk is high and was high in the preceding cycle. No extra rising edge occurs after the last bit.
- R7: load_n stays high for the whole time cs_n=0. After cs_n rises, load_n goes low for exactly one phase, which starts one phase after the chip-select release.
- R8: One phase after load_n returns high, ldac goes high for one phase. It then returns low, and it stays low for one further phase before done.
- R9: done is a one-cycle pulse. busy falls in that same cycle, and a start in that cycle is accepted.
- R10: A start while busy is ignored. The frames being sent do not change, and no extra transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a chain write; taken only while idle |
| frames | input | 24*CHAIN_LEN | One 24-bit word per device, word k for device k |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sclk | output | 1 | Serial clock to the chain, idles high |
| cs_n | output | 1 | Shared chip-select, active low |
| sdata | output | 1 | Serial data to the first device |
| load_n | output | 1 | Input-register load strobe, active low |
| ldac | output | 1 | Output latch; the rising edge updates all devices |

## Verification
The hardest situations to reach from the ports are two. The first is a start that coincides with the single done cycle. The second is a start with different frames held high in the middle of a shift. Both must land on a specific system cycle inside a phase grid set by the divider. The stimulus waits for done, or counts cycles after acceptance, and drives start on the matching falling edge. A behavioural cycle model then tells whether the request had to be taken or dropped. The stimulus also sends frame patterns with alternating, all-ones and single-bit content. These make sure that a misordered word or an off-by-one bit count shows up on sdata.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int FRAME_W = 24;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_CS_REL,
    ST_LOAD_LO,
    ST_LOAD_HI,
    ST_LATCH_HI,
    ST_LATCH_LO
  } seq_state_t;
endpackage

// File: rtl/dac_tick_gen.sv
module dac_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] load_val,
  input  logic             advance,
  output logic             head,
  output logic             last
);
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NBITS);

  logic [NBITS-1:0] sr;
  logic [CNT_W-1:0] sent;

  assign head = sr[NBITS-1];
  assign last = (sent == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      sent <= '0;
    end else if (load) begin
      sr   <= load_val;
      sent <= '0;
    end else if (advance) begin
      sr   <= {sr[NBITS-2:0], 1'b0};
      sent <= sent + 1'b1;
    end
  end
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
  import dac_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 3,
  parameter int CLK_DIV   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [CHAIN_LEN*FRAME_W-1:0]   frames,
  output logic                           busy,
  output logic                           done,
  output logic                           sclk,
  output logic                           cs_n,
  output logic                           sdata,
  output logic                           load_n,
  output logic                           ldac
);
  localparam int NBITS = CHAIN_LEN * FRAME_W;

  seq_state_t state;
  logic       tick;
  logic       accept;
  logic       advance;
  logic       head;
  logic       last;

  assign accept  = (state == ST_IDLE) && start;
  assign advance = tick && ((state == ST_CS_SETUP) ||
                            (state == ST_BIT_HI && !last));

  dac_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .restart (accept),
    .tick    (tick)
  );

  dac_bit_shifter #(.NBITS(NBITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (frames),
    .advance  (advance),
    .head     (head),
    .last     (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      sclk   <= 1'b1;
      cs_n   <= 1'b1;
      sdata  <= 1'b0;
      load_n <= 1'b1;
      ldac   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state <= ST_CS_SETUP;
          busy  <= 1'b1;
          cs_n  <= 1'b0;
        end
      end else if (tick) begin
        unique case (state)
          ST_CS_SETUP: begin
            state <= ST_BIT_LO;
            sclk  <= 1'b0;
            sdata <= head;
          end
          ST_BIT_LO: begin
            state <= ST_BIT_HI;
            sclk  <= 1'b1;
          end
          ST_BIT_HI: begin
            if (last) begin
              state <= ST_CS_REL;
              cs_n  <= 1'b1;
              sdata <= 1'b0;
            end else begin
              state <= ST_BIT_LO;
              sclk  <= 1'b0;
              sdata <= head;
            end
          end
          ST_CS_REL: begin
            state  <= ST_LOAD_LO;
            load_n <= 1'b0;
          end
          ST_LOAD_LO: begin
            state  <= ST_LOAD_HI;
            load_n <= 1'b1;
          end
          ST_LOAD_HI: begin
            state <= ST_LATCH_HI;
            ldac  <= 1'b1;
          end
          ST_LATCH_HI: begin
            state <= ST_LATCH_LO;
            ldac  <= 1'b0;
          end
          ST_LATCH_LO: begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_chain_host_chk.sv
module dac_chain_host_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic sdata,
  input logic load_n,
  input logic ldac
);
  assert_clk_low_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !sclk |-> !cs_n);

  assert_data_stable_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdata));

  assert_cs_rise_clk_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (sclk && $past(sclk)));

  assert_load_outside_frame_R7: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> cs_n);

  assert_ldac_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ldac |-> (cs_n && load_n && busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !ldac && $past(busy)));
endmodule

bind dac_chain_host dac_chain_host_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .sclk   (sclk),
  .cs_n   (cs_n),
  .sdata  (sdata),
  .load_n (load_n),
  .ldac   (ldac)
);

// File: tb/tb_dac_chain_host.sv
module tb_dac_chain_host;
  localparam int CLK_PERIOD = 10;
  localparam int CHAIN      = 2;
  localparam int DIV        = 3;
  localparam int NB         = CHAIN * 24;
  localparam int PH_TOTAL   = 2 * NB + 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] frames = '0;
  logic busy, done, sclk, cs_n, sdata, load_n, ldac;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  int            m_c = -1;
  logic [NB-1:0] m_fv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_host #(.CHAIN_LEN(CHAIN), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .frames(frames),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
    .sdata(sdata), .load_n(load_n), .ldac(ldac)
  );

  // Behavioural reference: cycle count since acceptance
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      m_c = -1;
    end else if ((m_c < 0 || m_c == PH_TOTAL * DIV) && start) begin
      m_c  = 0;
      m_fv = frames;
    end else if (m_c >= 0) begin
      m_c = m_c + 1;
      if (m_c > PH_TOTAL * DIV) m_c = -1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int   ph;
      logic e_busy, e_done, e_sclk, e_cs, e_data, e_load, e_ldac;
      ph     = (m_c < 0) ? -1 : m_c / DIV;
      e_done = (m_c == PH_TOTAL * DIV);
      e_busy = (m_c >= 0) && !e_done;
      e_cs   = !(ph >= 0 && ph <= 2 * NB);
      e_sclk = 1'b1;
      e_data = 1'b0;
      if (ph >= 1 && ph <= 2 * NB) begin
        e_sclk = ((ph % 2) == 0);
        e_data = m_fv[NB - 1 - (ph - 1) / 2];
      end
      e_load = !(ph == 2 * NB + 2);
      e_ldac = (ph == 2 * NB + 4);
      chk("R3/R5 sclk", sclk, e_sclk);
      chk("R2/R6 cs_n", cs_n, e_cs);
      chk("R4/R10 sdata", sdata, e_data);
      chk("R7 load_n", load_n, e_load);
      chk("R8 ldac", ldac, e_ldac);
      chk("R9 done", done, e_done);
      chk("R2/R9 busy", busy, e_busy);
    end
  end

  task automatic pulse_start(input logic [NB-1:0] f);
    @(negedge clk);
    frames = f;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 sclk", sclk, 1'b1);
    chk("R1 load_n", load_n, 1'b1);
    chk("R1 ldac", ldac, 1'b0);
    chk("R1 busy", busy, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4: alternating pattern
    pulse_start({24'hA5_3C_0F, 24'h80_0001});
    wait_done();
    repeat (4) @(negedge clk);

    // R10: start with other frames while busy
    pulse_start({24'hFFFFFF, 24'h000000});
    repeat (40) @(negedge clk);
    frames = {24'h123456, 24'h654321};
    start  = 1'b1;
    repeat (5) @(negedge clk);
    start  = 1'b0;
    wait_done();

    // R9: start in the done cycle is accepted
    frames = {24'h800000, 24'h000001};
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    wait_done();
    @(negedge clk);
    // R1: idle after completion
    chk("R1 idle busy", busy, 1'b0);
    chk("R1 idle sdata", sdata, 1'b0);
    repeat (10) @(negedge clk);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule